// File: doc/BRIEF.md
# SIMT Lane Execution-Mask Unit

This block is the scalar-side controller that decides which lanes of a wide vector datapath are active. It keeps a per-lane enable register, called the execution mask, and a small file of scalar mask registers. Each accepted operation reads up to two mask operands and writes one result. An operand can be a scalar mask register, the execution mask, or the compare-result mask that the vector lanes drive.

The operations come in two kinds. A save-and-modify operation records the execution mask as it stood before the operation into a scalar register, and in the same cycle narrows the mask with AND or widens it with OR. A plain logical operation (AND, OR, XOR, AND-with-inverted-second-operand, move) writes its result into a scalar register or into the execution mask. A compiler can combine these to build nested divergent if/else regions and loops with break lanes, with no hardware stack. Entering an if region uses an AND save with the compare mask followed by an XOR that isolates the else lanes. The else region uses an OR save followed by an XOR of the execution mask. The end of a region ORs the saved lanes back in. A loop end clears the break lanes from the mask, and a break collects the active lanes into a break mask with an OR.

The block also holds a scalar flag that reports whether the last result was nonzero. It drives two branch indications from the current execution mask, one for all lanes off and one for any lane on, which a sequencer uses to skip empty regions or to take a backward loop branch. The operation input is a valid/ready stream. Ready is always high because every operation finishes in the cycle it is accepted, so the unit never applies back-pressure. An operation is consumed on every rising clock edge where valid is high.

Top module: `lane_exec_ctrl`

## Requirements
- R1: After reset the execution mask is all ones, every scalar mask register is zero, the flag is 0, the all-off branch indication is 0, the any-on indication is 1 and op_ready is 1.
- R2: Opcode 1 (AND save) writes the pre-operation execution mask into register dst and sets the execution mask to the old mask AND operand A. The result is visible the cycle after acceptance.
- R3: Opcode 2 (OR save) writes the pre-operation execution mask into register dst and sets the execution mask to the old mask OR operand A.
- R4: Opcodes 3 AND, 4 OR, 5 XOR, 6 A AND NOT B and 7 move-A write their result into the scalar register selected by dst when dst is below NREG (8 by default).
- R5: A logical operation whose dst equals NREG (index 8) writes its result into the execution mask instead of a register.
- R6: Every operation with opcode 1 to 7 sets the flag to 1 when its result is nonzero and to 0 otherwise. For a save operation the result is the new execution mask. Opcode 0 and opcodes 8 to 15 change nothing and leave the flag as it was.
- R7: The all-off branch indication is 1 exactly when all execution bits are clear, and the any-on indication is its complement.
- R8: Operand index NREG selects the execution mask as it was before the operation, and index NREG+1 (9) selects the lane compare mask. Indices 0 to NREG-1 select scalar registers.
- R9: While op_valid is low, no register, mask or flag changes. op_ready is always 1.
- R10: A save operation with dst equal to NREG still updates the execution mask and writes no scalar register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_ready | output | 1 | Always 1; the unit takes an operation every cycle |
| op_code | input | 4 | Operation code (see R2 to R6) |
| dst_idx | input | 4 | Destination: register 0..NREG-1, or NREG for the execution mask |
| a_idx | input | 4 | Operand A selector (see R8) |
| b_idx | input | 4 | Operand B selector (see R8) |
| lane_cond | input | 64 | Per-lane compare result from the vector lanes |
| exec_mask | output | 64 | Current per-lane execution enables |
| scc | output | 1 | Nonzero-result flag |
| br_execz | output | 1 | Branch indication: no lane enabled |
| br_execnz | output | 1 | Branch indication: at least one lane enabled |

## Verification
The properties assume that op_code, dst_idx and the operand selectors are stable and defined on every clock edge where op_valid is high. They also assume that reset is held for at least one edge before the first operation, so each past value they read is a reset value or a value the unit produced itself. The bench drives every input at the falling edge and keeps all selectors in range for the scenario at hand. It reads scalar registers back only by moving them through the execution mask, using a scratch register that the scenarios do not use for data.

// File: rtl/lec_pkg.sv
package lec_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_AND_SAVE = 4'd1,
    OP_OR_SAVE  = 4'd2,
    OP_AND      = 4'd3,
    OP_OR       = 4'd4,
    OP_XOR      = 4'd5,
    OP_ANDN2    = 4'd6,
    OP_MOV      = 4'd7
  } mask_op_e;

  localparam int OP_W = 4;

endpackage

// File: rtl/lec_src_mux.sv
module lec_src_mux
  import lec_pkg::*;
#(
  parameter int LANES = 64,
  parameter int NREG  = 8,
  parameter int IDX_W = 4
) (
  input  logic [NREG-1:0][LANES-1:0] regs_i,
  input  logic [LANES-1:0]           exec_i,
  input  logic [LANES-1:0]           cond_i,
  input  logic [IDX_W-1:0]           sel_i,
  output logic [LANES-1:0]           val_o
);

  localparam logic [IDX_W-1:0] SEL_EXEC = IDX_W'(NREG);
  localparam logic [IDX_W-1:0] SEL_COND = IDX_W'(NREG + 1);

  always_comb begin
    val_o = '0;
    if (sel_i == SEL_EXEC) begin
      val_o = exec_i;
    end else if (sel_i == SEL_COND) begin
      val_o = cond_i;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (sel_i == IDX_W'(i)) val_o = regs_i[i];
      end
    end
  end

endmodule

// File: rtl/lec_mask_alu.sv
module lec_mask_alu
  import lec_pkg::*;
#(
  parameter int LANES = 64,
  parameter int NREG  = 8,
  parameter int IDX_W = 4
) (
  input  mask_op_e           op_i,
  input  logic [IDX_W-1:0]   dst_i,
  input  logic [LANES-1:0]   exec_i,
  input  logic [LANES-1:0]   a_i,
  input  logic [LANES-1:0]   b_i,
  output logic               exec_we_o,
  output logic [LANES-1:0]   exec_d_o,
  output logic               reg_we_o,
  output logic [LANES-1:0]   reg_d_o,
  output logic               flag_we_o,
  output logic               flag_d_o
);

  localparam logic [IDX_W-1:0] SEL_EXEC = IDX_W'(NREG);

  logic [LANES-1:0] result;
  logic             is_save;
  logic             is_logic;
  logic             dst_is_reg;

  assign dst_is_reg = (dst_i < SEL_EXEC);

  always_comb begin
    result   = '0;
    is_save  = 1'b0;
    is_logic = 1'b0;
    case (op_i)
      OP_AND_SAVE: begin result = exec_i & a_i;  is_save  = 1'b1; end
      OP_OR_SAVE:  begin result = exec_i | a_i;  is_save  = 1'b1; end
      OP_AND:      begin result = a_i & b_i;     is_logic = 1'b1; end
      OP_OR:       begin result = a_i | b_i;     is_logic = 1'b1; end
      OP_XOR:      begin result = a_i ^ b_i;     is_logic = 1'b1; end
      OP_ANDN2:    begin result = a_i & ~b_i;    is_logic = 1'b1; end
      OP_MOV:      begin result = a_i;           is_logic = 1'b1; end
      default:     begin result = '0;                             end
    endcase
  end

  always_comb begin
    exec_we_o = 1'b0;
    exec_d_o  = result;
    reg_we_o  = 1'b0;
    reg_d_o   = result;
    flag_we_o = is_save | is_logic;
    flag_d_o  = |result;
    if (is_save) begin
      exec_we_o = 1'b1;
      reg_we_o  = dst_is_reg;
      reg_d_o   = exec_i;
    end else if (is_logic) begin
      exec_we_o = (dst_i == SEL_EXEC);
      reg_we_o  = dst_is_reg;
    end
  end

endmodule

// File: rtl/lec_mask_regfile.sv
module lec_mask_regfile #(
  parameter int LANES = 64,
  parameter int NREG  = 8,
  parameter int IDX_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [LANES-1:0]           d_i,
  output logic [NREG-1:0][LANES-1:0] regs_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_o[g] <= '0;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        regs_o[g] <= d_i;
      end
    end
  end

endmodule

// File: rtl/lane_exec_ctrl.sv
module lane_exec_ctrl
  import lec_pkg::*;
#(
  parameter int LANES = 64,
  parameter int NREG  = 8,
  parameter int IDX_W = $clog2(NREG + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [OP_W-1:0]  op_code,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [LANES-1:0] lane_cond,
  output logic [LANES-1:0] exec_mask,
  output logic             scc,
  output logic             br_execz,
  output logic             br_execnz
);

  logic [NREG-1:0][LANES-1:0] regs;
  logic [LANES-1:0]           opnd_a;
  logic [LANES-1:0]           opnd_b;
  mask_op_e                   op_eff;
  logic                       exec_we;
  logic [LANES-1:0]           exec_d;
  logic                       reg_we;
  logic [LANES-1:0]           reg_d;
  logic                       flag_we;
  logic                       flag_d;

  assign op_ready = 1'b1;
  assign op_eff   = op_valid ? mask_op_e'(op_code) : OP_NOP;

  lec_src_mux #(.LANES(LANES), .NREG(NREG), .IDX_W(IDX_W)) u_mux_a (
    .regs_i(regs), .exec_i(exec_mask), .cond_i(lane_cond),
    .sel_i(a_idx), .val_o(opnd_a)
  );

  lec_src_mux #(.LANES(LANES), .NREG(NREG), .IDX_W(IDX_W)) u_mux_b (
    .regs_i(regs), .exec_i(exec_mask), .cond_i(lane_cond),
    .sel_i(b_idx), .val_o(opnd_b)
  );

  lec_mask_alu #(.LANES(LANES), .NREG(NREG), .IDX_W(IDX_W)) u_alu (
    .op_i(op_eff), .dst_i(dst_idx), .exec_i(exec_mask),
    .a_i(opnd_a), .b_i(opnd_b),
    .exec_we_o(exec_we), .exec_d_o(exec_d),
    .reg_we_o(reg_we), .reg_d_o(reg_d),
    .flag_we_o(flag_we), .flag_d_o(flag_d)
  );

  lec_mask_regfile #(.LANES(LANES), .NREG(NREG), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .idx_i(dst_idx),
    .d_i(reg_d), .regs_o(regs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_mask <= '1;
      scc       <= 1'b0;
    end else begin
      if (exec_we) exec_mask <= exec_d;
      if (flag_we) scc       <= flag_d;
    end
  end

  assign br_execz  = ~|exec_mask;
  assign br_execnz = |exec_mask;

endmodule

// File: rtl/lec_checker.sv
module lec_checker
  import lec_pkg::*;
#(
  parameter int LANES = 64,
  parameter int NREG  = 8,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [OP_W-1:0]  op_code,
  input logic [IDX_W-1:0] dst_idx,
  input logic [LANES-1:0] exec_mask,
  input logic             scc
);

  localparam logic [IDX_W-1:0] SEL_EXEC = IDX_W'(NREG);

  logic writes_exec;
  assign writes_exec = op_valid &&
    ((op_code == OP_AND_SAVE) || (op_code == OP_OR_SAVE) ||
     ((op_code >= OP_AND) && (op_code <= OP_MOV) && (dst_idx == SEL_EXEC)));

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(exec_mask) && $stable(scc))); // R9

  AST_AND_SAVE_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_AND_SAVE) |=> ((exec_mask & ~$past(exec_mask)) == '0)); // R2

  AST_OR_SAVE_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_OR_SAVE) |=> (($past(exec_mask) & ~exec_mask) == '0)); // R3

  AST_FLAG_MATCHES_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    writes_exec |=> (scc == (exec_mask != '0))); // R6

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_NOP || op_code > OP_MOV)) |=> ($stable(exec_mask) && $stable(scc))); // R6

endmodule

bind lane_exec_ctrl lec_checker #(.LANES(LANES), .NREG(NREG), .IDX_W(IDX_W)) u_lec_checker (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .dst_idx(dst_idx), .exec_mask(exec_mask), .scc(scc)
);

// File: tb/test_lane_exec_ctrl.sv
module test_lane_exec_ctrl;

  localparam int LANES = 64;
  localparam int NREG  = 8;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] EX = 4'd8;
  localparam logic [IDX_W-1:0] CD = 4'd9;
  localparam logic [IDX_W-1:0] SCR = 4'd7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             op_valid = 1'b0;
  logic             op_ready;
  logic [3:0]       op_code = 4'd0;
  logic [IDX_W-1:0] dst_idx = '0;
  logic [IDX_W-1:0] a_idx = '0;
  logic [IDX_W-1:0] b_idx = '0;
  logic [LANES-1:0] lane_cond = '0;
  logic [LANES-1:0] exec_mask;
  logic             scc;
  logic             br_execz;
  logic             br_execnz;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lane_exec_ctrl #(.LANES(LANES), .NREG(NREG)) i_lane_exec_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .dst_idx(dst_idx), .a_idx(a_idx), .b_idx(b_idx),
    .lane_cond(lane_cond), .exec_mask(exec_mask), .scc(scc),
    .br_execz(br_execz), .br_execnz(br_execnz)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [IDX_W-1:0] d,
                       input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] b,
                       input logic [63:0] c, input logic v = 1'b1);
    op_code = op; dst_idx = d; a_idx = a; b_idx = b; lane_cond = c; op_valid = v;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic peek(input logic [IDX_W-1:0] r, output logic [63:0] val);
    issue(4'd7, SCR, EX, 4'd0, '0);
    issue(4'd7, EX, r, 4'd0, '0);
    val = exec_mask;
    issue(4'd7, EX, SCR, 4'd0, '0);
  endtask

  task automatic t_reset();
    logic [63:0] v;
    check("R1 exec", exec_mask, '1);
    check("R1 scc", 64'(scc), 0);
    check("R1 execz", 64'(br_execz), 0);
    check("R1 execnz", 64'(br_execnz), 1);
    check("R1 ready", 64'(op_ready), 1);
    peek(4'd0, v);
    check("R1 r0", v, 0);
  endtask

  task automatic t_if_else();
    logic [63:0] c = 64'h00FF_00FF_F0F0_1234;
    logic [63:0] v;
    issue(4'd1, 4'd0, CD, 4'd0, c);
    check("R2 exec", exec_mask, c);
    check("R6 scc", 64'(scc), 1);
    issue(4'd5, 4'd0, 4'd0, EX, '0);
    issue(4'd2, 4'd1, 4'd0, 4'd0, '0);
    check("R3 exec", exec_mask, '1);
    peek(4'd1, v);
    check("R3 saved", v, c);
    peek(4'd0, v);
    check("R4 r0", v, ~c);
    issue(4'd5, EX, EX, 4'd1, '0);
    check("R5 exec", exec_mask, ~c);
    issue(4'd4, EX, EX, 4'd1, '0);
    check("R5 restore", exec_mask, '1);
  endtask

  task automatic t_loop();
    logic [63:0] v;
    issue(4'd7, EX, CD, 4'd0, 64'hF);
    issue(4'd4, 4'd2, EX, 4'd2, '0);
    peek(4'd2, v);
    check("R8 brk", v, 64'hF);
    issue(4'd6, EX, EX, 4'd2, '0);
    check("R7 exec", exec_mask, 0);
    check("R7 execz", 64'(br_execz), 1);
    check("R7 execnz", 64'(br_execnz), 0);
    check("R6 scc0", 64'(scc), 0);
    issue(4'd7, EX, CD, 4'd0, '1);
    issue(4'd6, EX, EX, CD, 64'hF0);
    check("R7 partial", exec_mask, ~64'hF0);
    check("R7 nz", 64'(br_execnz), 1);
  endtask

  task automatic t_idle();
    logic [63:0] v;
    issue(4'd7, EX, CD, 4'd0, '1);
    issue(4'd3, EX, CD, CD, 64'h0, 1'b0);
    check("R9 idle", exec_mask, '1);
    issue(4'd1, 4'd3, CD, 4'd0, 64'h0, 1'b0);
    peek(4'd3, v);
    check("R9 reg", v, 0);
    issue(4'd4, 4'd6, 4'd6, 4'd6, '0);
    check("R6 zero", 64'(scc), 0);
    issue(4'd7, 4'd6, CD, 4'd0, 64'h5);
    check("R6 one", 64'(scc), 1);
    issue(4'd0, EX, CD, 4'd0, 64'h0);
    check("R6 nop", exec_mask, '1);
    issue(4'd9, EX, CD, 4'd0, 64'h0);
    check("R6 undef", exec_mask, '1);
    check("R6 held", 64'(scc), 1);
  endtask

  task automatic t_save_noreg();
    logic [63:0] v;
    issue(4'd7, 4'd4, CD, 4'd0, 64'hAA);
    issue(4'd1, EX, CD, 4'd0, 64'h3);
    check("R10 exec", exec_mask, 64'h3);
    peek(4'd4, v);
    check("R10 r4", v, 64'hAA);
    issue(4'd7, EX, CD, 4'd0, '1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_if_else();
    t_loop();
    t_idle();
    t_save_noreg();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule